// File: doc/BRIEF.md
# Occupancy-Steered Reclocking Buffer Controller

This block sits between a recovered audio bit stream and a locally synthesized master clock. Bits enter a ring buffer of three equal sections and leave it at the master-clock rate. The controller watches how full the buffer is and adjusts the frequency tuning word of an external direct digital synthesizer. Each adjustment is a single least-significant step, a tiny fraction of a part per million. The aim is to keep the fill level inside the middle section. The outer two sections act as guard margin. Once the two rates agree, the controller issues no further corrections.

At start-up, and whenever the reported sample rate changes, the tuning word is preset from the rate code. The word is computed for a master clock of 256 times the sample rate. This puts the loop close to lock from the first moment. The buffer pointers are re-centred at the same time. Both sides are modelled in one fabric clock, with a write strobe and a read strobe. Overflow and underflow of the whole buffer set sticky error flags and re-centre the pointers.

Top module: `fifo_clock_steer`

## Requirements
- R1: While reset is held: `ftw` is 0, `ftw_load` is 0, both error flags are 0, `fill` is HALF (384 with defaults) and `rd_vld` is 0.
- R2: A rate code of 0..5 means 44.1, 48, 88.2, 96, 176.4 and 192 kHz. Such a code, when it differs from the last one loaded (the first valid code after reset always counts), takes effect at the next clock edge. On that edge `ftw` becomes floor(fs*256*2^FTW_W/REF_HZ), `ftw_load` pulses for one cycle and `fill` returns to HALF.
- R3: Rate codes 6 and 7 are ignored. Re-applying the code already loaded causes no reload, so `ftw`, `ftw_load` and `fill` are unchanged.
- R4: Bits leave in the order they were written. After a re-centre, the first HALF reads return stale bits, and the reads after them return the bits written after the re-centre. `rd_bit` and `rd_vld` are valid one cycle after the read strobe.
- R5: `fill` rises by one for each accepted write and falls by one for each accepted read. It is unchanged when a write and a read fall in the same cycle.
- R6: At the end of an evaluation interval, if `fill` < SEC_BITS, `ftw` decreases by exactly one, together with a `ftw_load` pulse.
- R7: At the end of an evaluation interval, if `fill` >= 2*SEC_BITS, `ftw` increases by exactly one, together with a `ftw_load` pulse.
- R8: At the end of an interval with `fill` in the middle section, no step is taken. With balanced traffic, `ftw` stays still and `ftw_load` stays low.
- R9: An evaluation interval lasts `eval_cycles` clock cycles, or 2^20 cycles when `eval_cycles` is 0. At most one step is taken per interval, so consecutive steps are exactly one interval apart.
- R10: A write at `fill` == DEPTH with no read in the same cycle is dropped. It sets the sticky `ovf_err` flag and re-centres (`fill` becomes HALF).
- R11: A read at `fill` == 0 with no write in the same cycle is not served (`rd_vld` stays 0). It sets the sticky `unf_err` flag and re-centres.
- R12: `ftw` never changes without `ftw_load` in the same cycle. Outside a reload, every change is a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one incoming bit |
| wr_bit | input | 1 | Incoming audio bit |
| rd_en | input | 1 | Read strobe from the master-clock side |
| rd_bit | output | 1 | Bit read out, valid with rd_vld |
| rd_vld | output | 1 | A read was served in the previous cycle |
| rate_code | input | 3 | Sample-rate indication from the receiver |
| eval_cycles | input | 32 | Evaluation interval in cycles, 0 selects 2^20 |
| ftw | output | FTW_W | Synthesizer tuning word |
| ftw_load | output | 1 | One-cycle strobe when ftw changes |
| fill | output | clog2(3*SEC_BITS+1) | Current buffer occupancy in bits |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
The bench sets the fill level below and above the middle section. It then measures the spacing and the sign of the steps that follow. A design that stepped the wrong way, stepped more than once per interval, or miscounted the interval shows up as a wrong word or a wrong gap. Balanced traffic inside the middle section must produce no strobe at all. A controller that keeps correcting after lock would fail that check. Invalid and repeated rate codes must not reload, and all six presets are compared with values computed from the formula. The buffer is driven to full and to empty to check that the offending access is dropped, the flags stick and the pointers re-centre. A write-then-read run after a re-centre catches ordering or offset errors.

// File: rtl/fifo_clock_steer.sv
module fifo_clock_steer #(
  parameter int SEC_BITS = 256,
  parameter int FTW_W    = 32,
  parameter longint REF_HZ = 100_000_000,
  parameter int EVAL_DEF = 1 << 20
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic                               wr_bit,
  input  logic                               rd_en,
  output logic                               rd_bit,
  output logic                               rd_vld,
  input  logic [2:0]                         rate_code,
  input  logic [31:0]                        eval_cycles,
  output logic [FTW_W-1:0]                   ftw,
  output logic                               ftw_load,
  output logic [$clog2(3*SEC_BITS+1)-1:0]    fill,
  output logic                               ovf_err,
  output logic                               unf_err
);
  localparam int DEPTH = 3 * SEC_BITS;
  localparam int HALF  = DEPTH / 2;
  localparam int PW    = $clog2(DEPTH);
  localparam int FW    = $clog2(DEPTH + 1);

  function automatic logic [FTW_W-1:0] preset(input logic [2:0] c);
    logic [63:0] fs;
    case (c)
      3'd1:    fs = 64'd48000;
      3'd2:    fs = 64'd88200;
      3'd3:    fs = 64'd96000;
      3'd4:    fs = 64'd176400;
      3'd5:    fs = 64'd192000;
      default: fs = 64'd44100;
    endcase
    return FTW_W'(((fs * 64'd256) << FTW_W) / 64'(REF_HZ));
  endfunction

  logic [0:DEPTH-1] mem;
  logic [PW-1:0]    wr_ptr, rd_ptr, rd_ctr;
  logic [2:0]       rate_q;
  logic [31:0]      ecnt;

  wire [31:0] lim     = (eval_cycles == 32'd0) ? 32'(EVAL_DEF) : eval_cycles;
  wire rate_ok        = rate_code <= 3'd5;
  wire reload         = rate_ok && (rate_code != rate_q);
  wire ovf            = wr_en && !rd_en && (fill == FW'(DEPTH)) && !reload;
  wire unf            = rd_en && !wr_en && (fill == '0) && !reload;
  wire do_wr          = wr_en && !ovf && !reload;
  wire do_rd          = rd_en && !unf && !reload;
  wire eval_end       = (ecnt == lim - 32'd1);
  wire fill_lo        = fill < FW'(SEC_BITS);
  wire fill_hi        = fill >= FW'(2 * SEC_BITS);

  wire [PW-1:0] wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
  wire [PW-1:0] rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
  assign rd_ctr = (wr_ptr >= PW'(HALF)) ? wr_ptr - PW'(HALF) : wr_ptr + PW'(DEPTH - HALF);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= PW'(DEPTH - HALF);
      fill     <= FW'(HALF);
      rate_q   <= 3'd7;
      ftw      <= '0;
      ftw_load <= 1'b0;
      ecnt     <= '0;
      ovf_err  <= 1'b0;
      unf_err  <= 1'b0;
      rd_bit   <= 1'b0;
      rd_vld   <= 1'b0;
    end else begin
      rd_vld   <= do_rd;
      ftw_load <= 1'b0;
      if (do_rd) rd_bit <= mem[rd_ptr];
      if (reload || ovf || unf) begin
        rd_ptr <= rd_ctr;
        fill   <= FW'(HALF);
        ecnt   <= '0;
        if (ovf) ovf_err <= 1'b1;
        if (unf) unf_err <= 1'b1;
        if (reload) begin
          rate_q   <= rate_code;
          ftw      <= preset(rate_code);
          ftw_load <= 1'b1;
        end
      end else begin
        if (do_wr) wr_ptr <= wr_nxt;
        if (do_rd) rd_ptr <= rd_nxt;
        fill <= fill + FW'(do_wr) - FW'(do_rd);
        if (eval_end) begin
          ecnt <= '0;
          if (fill_lo) begin
            ftw      <= ftw - 1'b1;
            ftw_load <= 1'b1;
          end else if (fill_hi) begin
            ftw      <= ftw + 1'b1;
            ftw_load <= 1'b1;
          end
        end else begin
          ecnt <= ecnt + 32'd1;
        end
      end
    end
  end
endmodule

// File: rtl/fifo_clock_steer_chk.sv
module fifo_clock_steer_chk #(
  parameter int SEC_BITS = 256,
  parameter int FTW_W    = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic                            rd_en,
  input logic                            reload,
  input logic [FTW_W-1:0]                ftw,
  input logic                            ftw_load,
  input logic [$clog2(3*SEC_BITS+1)-1:0] fill,
  input logic                            ovf_err,
  input logic                            unf_err
);
  localparam int DEPTH = 3 * SEC_BITS;
  localparam int HALF  = DEPTH / 2;

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH);

  p_no_silent_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw != $past(ftw)) |-> ftw_load);

  p_single_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw_load && !$past(reload)) |->
      (ftw == $past(ftw) + FTW_W'(1) || ftw == $past(ftw) - FTW_W'(1)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && fill == DEPTH) |=> (ovf_err && fill == HALF));

  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && fill == 0) |=> (unf_err && fill == HALF));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> unf_err);
endmodule

bind fifo_clock_steer fifo_clock_steer_chk #(.SEC_BITS(SEC_BITS), .FTW_W(FTW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reload(reload),
  .ftw(ftw), .ftw_load(ftw_load), .fill(fill), .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/fifo_clock_steer_test.sv
module fifo_clock_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEC  = 256;
  localparam int HALF = 384;
  localparam int DEP  = 768;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_bit = 0, rd_en = 0;
  logic [2:0]  rate_code = 0;
  logic [31:0] eval_cycles = 16;
  logic        rd_bit, rd_vld, ftw_load, ovf_err, unf_err;
  logic [31:0] ftw;
  logic [9:0]  fill;
  int total = 0, bad = 0;
  logic [2:0] cur = 0;
  bit done = 0;

  fifo_clock_steer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
    .rd_bit(rd_bit), .rd_vld(rd_vld), .rate_code(rate_code), .eval_cycles(eval_cycles),
    .ftw(ftw), .ftw_load(ftw_load), .fill(fill), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_word(input int c);
    longint fs;
    case (c)
      1: fs = 48000; 2: fs = 88200; 3: fs = 96000;
      4: fs = 176400; 5: fs = 192000; default: fs = 44100;
    endcase
    return 32'(((fs * 256) << 32) / 100_000_000);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_rate(input logic [2:0] c);
    @(negedge clk); rate_code = c; cur = c;
    @(negedge clk);
  endtask

  task automatic fresh();
    set_rate(cur == 3'd0 ? 3'd1 : 3'd0);
  endtask

  task automatic writes(input int n);
    for (int i = 0; i < n; i++) begin wr_en = 1; wr_bit = i[0]; @(negedge clk); end
    wr_en = 0;
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) begin rd_en = 1; @(negedge clk); end
    rd_en = 0;
  endtask

  task automatic wait_load(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!ftw_load && gap < 5000);
  endtask

  task automatic t_reset();
    check("R1 ftw", ftw, 0);
    check("R1 load", ftw_load, 0);
    check("R1 flags", {ovf_err, unf_err}, 0);
    check("R1 fill", fill, HALF);
    check("R1 rd_vld", rd_vld, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 first preset", ftw, exp_word(0));
    check("R2 first load", ftw_load, 1);
    @(negedge clk);
    check("R2 load one cycle", ftw_load, 0);
  endtask

  task automatic t_rates();
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk); rate_code = 3'(c); cur = 3'(c);
      @(negedge clk);
      check("R2 preset word", ftw, exp_word(c));
      check("R2 preset load", ftw_load, 1);
      check("R2 recentre", fill, HALF);
    end
  endtask

  task automatic t_invalid();
    logic [31:0] w;
    int loads = 0;
    w = ftw;
    @(negedge clk); rate_code = 3'd6;
    repeat (20) begin @(negedge clk); loads += ftw_load; end
    rate_code = 3'd7;
    repeat (5) begin @(negedge clk); loads += ftw_load; end
    rate_code = cur;
    repeat (5) begin @(negedge clk); loads += ftw_load; end
    check("R3 no load", loads, 0);
    check("R3 word kept", ftw, w);
    check("R3 fill kept", fill, HALF);
  endtask

  task automatic t_data();
    logic [39:0] pat = 40'hA5_3C_96_0F_E1;
    int errs = 0;
    eval_cycles = 100000;
    fresh();
    for (int i = 0; i < 40; i++) begin wr_en = 1; wr_bit = pat[i]; @(negedge clk); end
    wr_en = 0;
    check("R5 fill after writes", fill, HALF + 40);
    for (int i = 0; i < HALF + 40; i++) begin
      rd_en = 1; @(negedge clk);
      if (i >= HALF && (rd_bit != pat[i-HALF] || !rd_vld)) errs++;
    end
    rd_en = 0;
    check("R4 order mismatches", errs, 0);
    check("R5 fill empty", fill, 0);
    rd_en = 1; @(negedge clk); rd_en = 0;
    check("R11 unf flag", unf_err, 1);
    check("R11 not served", rd_vld, 0);
    check("R11 recentre", fill, HALF);
  endtask

  task automatic t_ovf();
    writes(DEP - HALF);
    check("R5 full", fill, DEP);
    wr_en = 1; rd_en = 1; @(negedge clk); wr_en = 0; rd_en = 0;
    check("R5 simultaneous at full", fill, DEP);
    check("R10 no flag yet", ovf_err, 0);
    wr_en = 1; @(negedge clk); wr_en = 0;
    check("R10 ovf flag", ovf_err, 1);
    check("R10 recentre", fill, HALF);
    repeat (3) @(negedge clk);
    check("R11 unf sticky", unf_err, 1);
    check("R10 ovf sticky", ovf_err, 1);
  endtask

  task automatic t_steer();
    int gap;
    logic [31:0] w;
    eval_cycles = 16;
    fresh();
    reads(200);
    wait_load(gap);
    w = ftw;
    wait_load(gap);
    check("R9 step spacing low", gap, 16);
    check("R6 decrement", ftw, w - 1);
    writes(400);
    wait_load(gap);
    w = ftw;
    wait_load(gap);
    check("R9 step spacing high", gap, 16);
    check("R7 increment", ftw, w + 1);
  endtask

  task automatic t_lock();
    int loads = 0;
    logic [31:0] w;
    eval_cycles = 16;
    fresh();
    w = ftw;
    for (int i = 0; i < 100; i++) begin
      wr_en = 1; rd_en = 1; wr_bit = i[1]; @(negedge clk); loads += ftw_load;
    end
    wr_en = 0; rd_en = 0;
    check("R8 idle loads", loads, 0);
    check("R8 word kept", ftw, w);
    check("R5 balanced fill", fill, HALF);
  endtask

  task automatic t_default();
    int loads = 0;
    eval_cycles = 0;
    fresh();
    reads(200);
    repeat (2000) begin @(negedge clk); loads += ftw_load; end
    check("R9 default interval no early step", loads, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rates();
    t_invalid();
    t_data();
    t_ovf();
    t_steer();
    t_lock();
    t_default();
    finish_run();
  end
endmodule